// File: doc/BRIEF.md
# Single-Precision NaN Propagation Unit

This unit sits beside a single-precision arithmetic datapath and settles everything about NaN results that the arithmetic itself need not know. It sorts each of two 32-bit operands into one of six classes. When an operand is a NaN it decides which NaN becomes the result, and it applies signaling semantics to that result. The arithmetic result path takes `nan_out` whenever `nan_valid` is high.

The unit follows the older convention in which a set top fraction bit (bit 22) marks a *signaling* NaN and a clear one marks a *quiet* NaN. In single-operand operations only `op_a` counts. In two-operand operations the NaN with the larger fraction wins.

A signaling NaN raises `invalid`. With the trap disabled, the value is quieted by clearing bit 22. If that would leave a zero fraction, which reads as infinity, the unit substitutes a fixed default NaN. With the trap enabled, the raw signaling NaN is passed out together with `trap_req` so that outside logic can take over. A parameter selects a registered output stage, which is on by default.

Top module: `sp_nan_prop`

## Requirements
- R1: Each operand gets a 3-bit class code. It is 0 for zero (exponent 0, fraction 0), 1 for normal, 2 for denormal (exponent 0, fraction not 0) and 3 for infinity (exponent 0xFF, fraction 0). It is 4 for a signaling NaN (exponent 0xFF, fraction bit 22 set) and 5 for a quiet NaN (exponent 0xFF, bit 22 clear, fraction not 0).
- R2: `nan_valid` is high exactly when an operand under consideration has a class code of 4 or more. `op_a` is always considered, and `op_b` only when `dual_op` is 1.
- R3: A quiet NaN result is output bit-for-bit unchanged, with `invalid` and `trap_req` low.
- R4: A signaling NaN result with `trap_en` low sets `invalid`. The output is that NaN with bit 22 cleared and every other bit kept, as long as the remaining fraction is not zero.
- R5: If clearing bit 22 leaves a zero fraction, the output is the default NaN 0x7FBFFFFF and `invalid` is set.
- R6: When both considered operands are NaN, the one whose 23-bit fraction is larger as an unsigned number is propagated. On equal fractions `op_b` is propagated.
- R7: When exactly one considered operand is NaN, that operand is propagated.
- R8: With `dual_op` low, `op_b` has no effect on `nan_valid`, `nan_out`, `invalid` or `trap_req`.
- R9: A signaling NaN result with `trap_en` high is output unquieted, with `invalid` and `trap_req` both high.
- R10: When no considered operand is NaN, `nan_valid`, `invalid` and `trap_req` are low and `nan_out` is 0.
- R11: With `REG_OUT`=1, all outputs reflect the inputs sampled at the previous rising clock edge. A synchronous `rst` drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| dual_op | input | 1 | 1: two-operand operation, 0: only op_a counts |
| trap_en | input | 1 | Invalid-operation trap enable |
| cls_a | output | 3 | Class code of op_a |
| cls_b | output | 3 | Class code of op_b |
| nan_valid | output | 1 | The result must be a NaN |
| nan_out | output | 32 | The propagated NaN |
| invalid | output | 1 | Invalid-operation flag |
| trap_req | output | 1 | Request for the external trap handler |

## Verification
With the default registered output, every result is due exactly one clock edge after its operands are applied. The bench drives operands on the falling edge and queues the expected outputs that a behavioural model computes from them. On the next falling edge it pops the queue and compares every output, so each comparison lines up with the single register stage. During reset the expected values are all zero, which covers the cycles before the first operands arrive.

// File: rtl/sp_nan_pkg.sv
package sp_nan_pkg;

    localparam int SP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = SP_W - EXP_W - 1;
    localparam int CLS_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ZERO   = 3'd0,
        CLS_NORM   = 3'd1,
        CLS_DENORM = 3'd2,
        CLS_INF    = 3'd3,
        CLS_SNAN   = 3'd4,
        CLS_QNAN   = 3'd5
    } fp_class_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } sp_word_t;

    localparam sp_word_t DEFAULT_NAN = sp_word_t'(32'h7FBF_FFFF);

    typedef struct packed {
        logic     valid;
        logic     sig;
        sp_word_t word;
    } nan_pick_t;

    typedef struct packed {
        logic     valid;
        sp_word_t word;
        logic     invalid;
        logic     trap;
    } nan_result_t;

    typedef struct packed {
        fp_class_e ca;
        fp_class_e cb;
        logic      nv;
        sp_word_t  word;
        logic      inv;
        logic      trap;
    } out_bundle_t;

    function automatic logic class_is_nan(fp_class_e c);
        return c >= CLS_SNAN;
    endfunction

endpackage

// File: rtl/sp_classify.sv
module sp_classify
    import sp_nan_pkg::*;
(
    input  sp_word_t  op,
    output fp_class_e cls
);
    logic exp_zero, exp_ones, frac_zero, top_bit;

    always_comb begin
        exp_zero  = (op.expo == '0);
        exp_ones  = (op.expo == '1);
        frac_zero = (op.frac == '0);
        top_bit   = op.frac[FRAC_W-1];
        if (exp_zero)
            cls = frac_zero ? CLS_ZERO : CLS_DENORM;
        else if (!exp_ones)
            cls = CLS_NORM;
        else if (frac_zero)
            cls = CLS_INF;
        else if (top_bit)
            cls = CLS_SNAN;
        else
            cls = CLS_QNAN;
    end
endmodule

// File: rtl/sp_nan_pick.sv
module sp_nan_pick
    import sp_nan_pkg::*;
(
    input  sp_word_t  op_a,
    input  sp_word_t  op_b,
    input  fp_class_e cls_a,
    input  fp_class_e cls_b,
    input  logic      dual_op,
    output nan_pick_t pick
);
    logic a_nan, b_nan, a_wins;

    always_comb begin
        a_nan  = class_is_nan(cls_a);
        b_nan  = dual_op && class_is_nan(cls_b);
        // strict compare: equal fractions fall to op_b
        a_wins = op_a.frac > op_b.frac;
        pick   = '0;
        if (a_nan && b_nan) begin
            pick.valid = 1'b1;
            pick.word  = a_wins ? op_a : op_b;
            pick.sig   = a_wins ? (cls_a == CLS_SNAN) : (cls_b == CLS_SNAN);
        end else if (a_nan) begin
            pick.valid = 1'b1;
            pick.word  = op_a;
            pick.sig   = (cls_a == CLS_SNAN);
        end else if (b_nan) begin
            pick.valid = 1'b1;
            pick.word  = op_b;
            pick.sig   = (cls_b == CLS_SNAN);
        end
    end
endmodule

// File: rtl/sp_nan_quiet.sv
module sp_nan_quiet
    import sp_nan_pkg::*;
(
    input  nan_pick_t   pick,
    input  logic        trap_en,
    output nan_result_t res
);
    sp_word_t cleared;

    always_comb begin
        cleared                 = pick.word;
        cleared.frac[FRAC_W-1]  = 1'b0;
        res                     = '0;
        res.valid               = pick.valid;
        if (pick.valid) begin
            if (!pick.sig) begin
                res.word = pick.word;
            end else if (trap_en) begin
                res.word    = pick.word;
                res.invalid = 1'b1;
                res.trap    = 1'b1;
            end else begin
                res.invalid = 1'b1;
                res.word    = (cleared.frac == '0) ? DEFAULT_NAN : cleared;
            end
        end
    end
endmodule

// File: rtl/sp_nan_prop.sv
module sp_nan_prop
    import sp_nan_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic        dual_op,
    input  logic        trap_en,
    output logic [2:0]  cls_a,
    output logic [2:0]  cls_b,
    output logic        nan_valid,
    output logic [31:0] nan_out,
    output logic        invalid,
    output logic        trap_req
);
    localparam int N_OPS = 2;

    sp_word_t    ops  [N_OPS];
    fp_class_e   cls  [N_OPS];
    nan_pick_t   pick;
    nan_result_t res;
    out_bundle_t comb_o, out_o;

    assign ops[0] = sp_word_t'(op_a);
    assign ops[1] = sp_word_t'(op_b);

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        sp_classify u_cls (
            .op  (ops[i]),
            .cls (cls[i])
        );
    end

    sp_nan_pick u_pick (
        .op_a    (ops[0]),
        .op_b    (ops[1]),
        .cls_a   (cls[0]),
        .cls_b   (cls[1]),
        .dual_op (dual_op),
        .pick    (pick)
    );

    sp_nan_quiet u_quiet (
        .pick    (pick),
        .trap_en (trap_en),
        .res     (res)
    );

    always_comb begin
        comb_o.ca   = cls[0];
        comb_o.cb   = cls[1];
        comb_o.nv   = res.valid;
        comb_o.word = res.word;
        comb_o.inv  = res.invalid;
        comb_o.trap = res.trap;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) out_o <= '0;
            else     out_o <= comb_o;
        end
    end else begin : g_comb
        assign out_o = comb_o;
    end

    assign cls_a     = out_o.ca;
    assign cls_b     = out_o.cb;
    assign nan_valid = out_o.nv;
    assign nan_out   = out_o.word;
    assign invalid   = out_o.inv;
    assign trap_req  = out_o.trap;

    // R9: a trap request always comes with the invalid flag
    a_r9_trap_with_invalid: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> invalid);

    // R4: an untrapped invalid result is quiet
    a_r4_untrapped_is_quiet: assert property (@(posedge clk) disable iff (rst)
        (invalid && !trap_req) |-> !nan_out[22]);

    // R2: a propagated value carries an all-ones exponent
    a_r2_nan_exponent: assert property (@(posedge clk) disable iff (rst)
        nan_valid |-> (nan_out[30:23] == 8'hFF));

    // R5: a propagated value never reads as infinity
    a_r5_never_infinity: assert property (@(posedge clk) disable iff (rst)
        nan_valid |-> (nan_out[22:0] != 23'd0));

    // R10: no flags and a zero word without a NaN result
    a_r10_idle_clean: assert property (@(posedge clk) disable iff (rst)
        !nan_valid |-> (!invalid && !trap_req && nan_out == 32'd0));

endmodule

// File: tb/test_sp_nan_prop.sv
module test_sp_nan_prop;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] op_a, op_b;
    logic        dual_op, trap_en;
    logic [2:0]  cls_a, cls_b;
    logic        nan_valid, invalid, trap_req;
    logic [31:0] nan_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    logic [40:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    sp_nan_prop i_sp_nan_prop (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .dual_op(dual_op), .trap_en(trap_en),
        .cls_a(cls_a), .cls_b(cls_b), .nan_valid(nan_valid),
        .nan_out(nan_out), .invalid(invalid), .trap_req(trap_req)
    );

    function automatic int class_of(logic [31:0] x);
        int e = int'(x[30:23]);
        int f = int'(x[22:0]);
        if (e == 0)   return (f == 0) ? 0 : 2;
        if (e != 255) return 1;
        if (f == 0)   return 3;
        return (f >= 32'h400000) ? 4 : 5;
    endfunction

    function automatic logic [40:0] model(logic [31:0] a, logic [31:0] b,
                                          logic two, logic te);
        int ca = class_of(a);
        int cb = class_of(b);
        bit an = ca >= 4;
        bit bn = two && cb >= 4;
        logic [31:0] r = 32'd0;
        bit v = 1'b0, inv = 1'b0, tr = 1'b0;
        if (an && bn) begin
            v = 1'b1;
            r = (a[22:0] > b[22:0]) ? a : b;
        end else if (an) begin
            v = 1'b1; r = a;
        end else if (bn) begin
            v = 1'b1; r = b;
        end
        if (v && r[22]) begin
            inv = 1'b1;
            if (te) tr = 1'b1;
            else begin
                r = r & ~32'h0040_0000;
                if (r[22:0] == 23'd0) r = 32'h7FBF_FFFF;
            end
        end
        return {ca[2:0], cb[2:0], v, r, inv, tr};
    endfunction

    function automatic logic [40:0] observed();
        return {cls_a, cls_b, nan_valid, nan_out, invalid, trap_req};
    endfunction

    task automatic compare(logic [40:0] e, string tag);
        logic [40:0] o = observed();
        n_checks++;
        if (o !== e) begin
            n_errors++;
            $display("FAIL %s: got cls=%0d/%0d v=%0b out=%08h inv=%0b trap=%0b, expected cls=%0d/%0d v=%0b out=%08h inv=%0b trap=%0b",
                     tag, o[40:38], o[37:35], o[34], o[33:2], o[1], o[0],
                     e[40:38], e[37:35], e[34], e[33:2], e[1], e[0]);
        end
    endtask

    // one cycle: check what is due, then apply new operands (falling edge)
    task automatic step(logic [31:0] a, logic [31:0] b, logic two,
                        logic te, string tag);
        @(negedge clk);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        op_a = a; op_b = b; dual_op = two; trap_en = te;
        exp_q.push_back(model(a, b, two, te));
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got no end, expected end of run");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        op_a = 32'h7FC0_0001; op_b = 32'h7F81_0000;
        dual_op = 1'b1; trap_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(41'd0, "R11 reset");          // R11: outputs zero under reset
        rst = 1'b0;

        step(32'h3F80_0000, 32'h0000_0000, 1'b1, 1'b0, "R1 normal/zero");
        step(32'h8000_0001, 32'h7F80_0000, 1'b1, 1'b0, "R1 denorm/inf");
        step(32'hFF80_0000, 32'h0000_0000, 1'b1, 1'b0, "R10 no nan");
        step(32'h7F81_2345, 32'h3F80_0000, 1'b1, 1'b0, "R3 quiet pass");
        step(32'hFF81_2345, 32'h0000_0000, 1'b1, 1'b1, "R3 quiet trap_en");
        step(32'hFFE0_0000, 32'h0000_0000, 1'b1, 1'b0, "R4 quieted");
        step(32'h7FC0_0000, 32'h3F80_0000, 1'b1, 1'b0, "R5 default nan");
        step(32'h7F81_2345, 32'hFF81_2345, 1'b1, 1'b0, "R6 tie to b");
        step(32'h7F81_2346, 32'hFF81_2345, 1'b1, 1'b0, "R6 larger a");
        step(32'h7F80_0001, 32'h7FC0_0000, 1'b1, 1'b0, "R6 snan larger");
        step(32'h3F80_0000, 32'h7FC0_0003, 1'b1, 1'b0, "R7 b only");
        step(32'h3F80_0000, 32'h7FC0_0003, 1'b0, 1'b0, "R8 b ignored");
        step(32'h7F80_0010, 32'h7FFF_FFFF, 1'b0, 1'b1, "R8 b ignored nan a");
        step(32'h7FC0_0000, 32'h0000_0000, 1'b1, 1'b1, "R9 trap raw");
        step(32'hFFD0_0000, 32'h7F80_0005, 1'b1, 1'b1, "R9 trap pick");
        step(32'h7FC0_0001, 32'h7FC0_0001, 1'b1, 1'b0, "R6 tie snan");

        for (int i = 0; i < 300; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            if (i % 3 != 0) a[30:23] = 8'hFF;
            if (i % 2 == 0) b[30:23] = 8'hFF;
            if (i % 7 == 0) a[22:0] = {1'b1, 22'd0};
            if (i % 11 == 0) b[22:0] = a[22:0];
            step(a, b, 1'($urandom), 1'($urandom), "R11 random R1 R6");
        end
        step(32'd0, 32'd0, 1'b0, 1'b0, "R10 drain");
        finish_run();
    end

endmodule